// File: doc/BRIEF.md
# Four-Phase Stepper Coil Sequencer

This block drives the four coil enables of a four-phase stepper motor. Each coil enable feeds one opposite pair of stator windings. A 1 on a coil enable means positive drive and a 0 means neutral. Reverse drive is never produced.

The block keeps two pieces of state:

- a timebase level, built from a strobe input by a chain of divide-by-two stages;
- a half-rate toggle that flips on every falling edge of that timebase.

The four coil enables are the four AND terms of {timebase, NOT timebase} with {toggle, NOT toggle}. Exactly one coil is active at any time, and the active coil moves one place on every timebase edge, rising or falling.

Everything runs on one system clock, and no clock is derived from the timebase. With `DIV_STAGES = 1`, each strobe on `step_tick` is itself a timebase edge. With `DIV_STAGES = 15` and a 32768 Hz reference strobe, the timebase is a 1 Hz square wave. The reset input is synchronous and active low, and is meant for a debounced push button.

Top module: `stepper_coil_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After that edge `coil_en` is 4'b1000 (coil D), `tb_level` is 0 and the toggle is 0.
- R2: Exactly one bit of `coil_en` is 1 in every cycle after reset.
- R3: The coil bits are decoded from the timebase level and the toggle as follows:
  - bit 0 (A) is timebase high with toggle low;
  - bit 1 (B) is timebase low with toggle high;
  - bit 2 (C) is timebase high with toggle high;
  - bit 3 (D) is timebase low with toggle low.
  
  As a result, `tb_level` is 1 exactly when coil A or coil C is active.
- R4: Each timebase edge moves the active coil through A, B, C, D and back to A. This means `coil_en` rotates one place toward the higher bit, and bit 3 wraps to bit 0. The new value appears after the clock edge that samples the strobe.
- R5: The toggle flips only on falling timebase edges. The pattern therefore repeats after four timebase edges, and the first edge after reset selects coil A.
- R6: With `DIV_STAGES = 1`, every cycle in which `step_tick` is 1 is a timebase edge, including strobes on consecutive cycles.
- R7: With `DIV_STAGES = N > 1`, a timebase edge occurs on every 2^(N-1)-th strobe counted from reset, and `tb_level` changes only at those strobes.
- R8: In a cycle without a timebase edge, `coil_en` and `tb_level` hold their values.
- R9: Reset takes priority over a strobe that arrives in the same cycle. The block returns to the R1 state and does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (push button) |
| step_tick | input | 1 | One-cycle strobe: a timebase edge, or a reference tick when dividing |
| tb_level | output | 1 | Current timebase level |
| coil_en | output | 4 | Coil enables, bit 0 = A through bit 3 = D, 1 = positive drive |

## Verification
The hardest case to reach is a reset that lands on the same clock edge as a strobe. In that case the toggle and the divider would both move if reset did not win. The bench first steps the sequencer away from coil D. It then raises `rst_n` low and `step_tick` high on the same falling clock edge, and checks for coil D after the next rising edge.

In the divided variant, the divider's terminal count is reached only after a run of counted strobes. The bench drives a second instance with three stages through several full timebase periods. This confirms that only every fourth strobe moves the coils.

// File: rtl/stepper_pkg.sv
// Shared constants and phase decode rules for the stepper coil sequencer.
// Assumes four coils, indexed A=0, B=1, C=2, D=3.
package stepper_pkg;

    localparam int COILS = 4;

    typedef logic [COILS-1:0] coil_t;

    // Coil D: timebase low, toggle low. This is the state reset leaves behind.
    localparam coil_t COIL_RESET = coil_t'(4'b1000);

    // Timebase level that a coil needs: A and C need high, B and D need low.
    function automatic logic tb_need(input int unsigned idx);
        return ~idx[0];
    endfunction

    // Toggle level that a coil needs: B and C need high, A and D need low.
    function automatic logic tg_need(input int unsigned idx);
        return idx[0] ^ idx[1];
    endfunction

endpackage

// File: rtl/tb_divider.sv
// Timebase divider. It counts strobes with a chain of DIV_STAGES
// divide-by-two stages and takes the last stage as the timebase level.
// It also flags the strobes that flip that level.
// Assumes step_tick lasts one cycle per event. With DIV_STAGES = 1,
// every strobe is a timebase edge.
module tb_divider #(
    parameter int DIV_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_tick,
    output logic tb_level,
    output logic tb_edge,
    output logic tb_fall
);

    localparam int W = DIV_STAGES;

    logic [W-1:0] cnt;

    // Count strobes. The top bit is the timebase square wave.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step_tick)
            cnt <= cnt + W'(1);
    end

    generate
        if (W == 1) begin : g_direct
            // Every strobe flips the level.
            assign tb_edge = step_tick;
        end else begin : g_chain
            // A strobe flips the level only when all lower stages are at one.
            assign tb_edge = step_tick & (&cnt[W-2:0]);
        end
    endgenerate

    assign tb_level = cnt[W-1];
    // Falling edge: an edge taken while the level is high.
    assign tb_fall  = tb_edge & tb_level;

    // R7
    // edge_needs_tick_chk: the timebase never moves without a strobe.
    edge_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb_edge |-> step_tick);

    // R8
    // level_hold_chk: the level stays put in cycles without an edge.
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_edge |=> $stable(tb_level));

    // R7
    // level_flip_chk: every edge inverts the level.
    level_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb_edge |=> tb_level != $past(tb_level));

endmodule

// File: rtl/toggle_stage.sv
// Half-rate toggle stage. This flip-flop acts like a toggle flop with
// its T input held at 1 that fires on each falling timebase edge.
// It is kept synchronous through an enable and has no preset path.
module toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    output logic tg
);

    // Flip on each falling timebase edge; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tg <= 1'b0;
        else if (fall)
            tg <= ~tg;
    end

    // R5
    // toggle_hold_chk: the toggle moves only on a falling edge.
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(tg));

endmodule

// File: rtl/coil_decode.sv
// Coil decode. It builds one AND term per coil from the timebase level
// and the toggle. It is purely combinational and assumes the inputs are
// registered.
module coil_decode
    import stepper_pkg::*;
(
    input  logic  tb,
    input  logic  tg,
    output coil_t coil
);

    generate
        for (genvar i = 0; i < COILS; i++) begin : g_coil
            // Coil i is driven when both inputs match its phase.
            assign coil[i] = (tb == tb_need(i)) && (tg == tg_need(i));
        end
    endgenerate

endmodule

// File: rtl/stepper_coil_seq.sv
// Four-phase stepper coil sequencer, top level. The divider feeds the
// toggle stage, and both feed the coil decode. The coil step advances on
// both timebase edges. Assumes one system clock, a synchronous active-low
// reset and a strobe input that is already synchronised.
module stepper_coil_seq
    import stepper_pkg::*;
#(
    parameter int DIV_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_tick,
    output logic       tb_level,
    output logic [3:0] coil_en
);

    logic tb_edge;
    logic tb_fall;
    logic tg;

    tb_divider #(.DIV_STAGES(DIV_STAGES)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_tick(step_tick),
        .tb_level (tb_level),
        .tb_edge  (tb_edge),
        .tb_fall  (tb_fall)
    );

    toggle_stage u_tog (
        .clk  (clk),
        .rst_n(rst_n),
        .fall (tb_fall),
        .tg   (tg)
    );

    coil_decode u_dec (
        .tb  (tb_level),
        .tg  (tg),
        .coil(coil_en)
    );

    // R1
    // reset_state_chk: after a reset edge only coil D is on.
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> coil_en == COIL_RESET);

    // R2
    // one_hot_chk: exactly one coil is driven.
    one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(coil_en) == 1);

    // R4
    // rotate_chk: each edge moves drive to the next coil, wrapping D to A.
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb_edge |=> coil_en == {$past(coil_en[2:0]), $past(coil_en[3])});

    // R8
    // coil_hold_chk: no edge, no change.
    coil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_edge |=> $stable(coil_en));

    // R3
    // level_match_chk: timebase high exactly when A or C is driven.
    level_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb_level == (coil_en[0] | coil_en[2]));

endmodule

// File: tb/stepper_coil_seq_bench.sv
module stepper_coil_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_a = 1'b0;
    logic tick_b = 1'b0;
    logic lvl_a, lvl_b;
    logic [3:0] coil_a, coil_b;

    int n_chk = 0;
    int n_fail = 0;
    int ph_a = 3;      // bench model: 0=A .. 3=D
    int ph_b = 3;
    int cnt_b = 0;     // strobes seen by divided instance since reset

    always #5 clk = ~clk;

    stepper_coil_seq #(.DIV_STAGES(1)) u_stepper_coil_seq (
        .clk(clk), .rst_n(rst_n), .step_tick(tick_a),
        .tb_level(lvl_a), .coil_en(coil_a)
    );

    stepper_coil_seq #(.DIV_STAGES(3)) u_stepper_coil_seq_div (
        .clk(clk), .rst_n(rst_n), .step_tick(tick_b),
        .tb_level(lvl_b), .coil_en(coil_b)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] onehot(input int p);
        return 4'b0001 << p;
    endfunction

    function automatic logic [3:0] lvl_of(input int p);
        return {3'b000, (p == 0 || p == 2)};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_a = 1'b0;
        tick_b = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ph_a = 3;
        ph_b = 3;
        cnt_b = 0;
        // R1 reset state on both instances
        chk("R1 coil_a", coil_a, 4'b1000);
        chk("R1 coil_b", coil_b, 4'b1000);
        chk("R1 level_a", {3'b000, lvl_a}, 4'b0000);
        chk("R1 level_b", {3'b000, lvl_b}, 4'b0000);
    endtask

    // R4 R5 R6 R3 R2: sequence of single strobes on the direct instance
    task automatic t_sequence();
        for (int k = 0; k < 9; k++) begin
            @(negedge clk) tick_a = 1'b1;
            @(negedge clk) tick_a = 1'b0;
            ph_a = (ph_a + 1) % 4;
            chk("R4 order", coil_a, onehot(ph_a));
            chk("R3 level", {3'b000, lvl_a}, lvl_of(ph_a));
            chk("R2 onehot", {3'b000, ($countones(coil_a) == 1)}, 4'b0001);
        end
    endtask

    // R5: first edge after reset selects coil A
    task automatic t_first_step();
        do_reset();
        @(negedge clk) tick_a = 1'b1;
        @(negedge clk) tick_a = 1'b0;
        ph_a = 0;
        chk("R5 first step A", coil_a, 4'b0001);
    endtask

    // R8: no strobe, outputs hold
    task automatic t_idle();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R8 hold coil", coil_a, onehot(ph_a));
            chk("R8 hold level", {3'b000, lvl_a}, lvl_of(ph_a));
        end
    endtask

    // R6: strobes on consecutive cycles each advance
    task automatic t_back_to_back();
        @(negedge clk) tick_a = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            ph_a = (ph_a + 1) % 4;
            chk("R6 consecutive", coil_a, onehot(ph_a));
            if (k == 4) tick_a = 1'b0;
        end
        @(negedge clk);
        chk("R6 after burst", coil_a, onehot(ph_a));
    endtask

    // R7: divided instance moves on every fourth strobe
    task automatic t_divided();
        for (int k = 0; k < 17; k++) begin
            @(negedge clk) tick_b = 1'b1;
            @(negedge clk) tick_b = 1'b0;
            cnt_b++;
            if (cnt_b % 4 == 0) ph_b = (ph_b + 1) % 4;
            chk("R7 divided coil", coil_b, onehot(ph_b));
            chk("R7 divided level", {3'b000, lvl_b}, lvl_of(ph_b));
        end
    endtask

    // R9: reset wins over a strobe in the same cycle
    task automatic t_reset_collide();
        @(negedge clk) tick_a = 1'b1;
        @(negedge clk) tick_a = 1'b0;
        ph_a = (ph_a + 1) % 4;
        @(negedge clk);
        rst_n = 1'b0;
        tick_a = 1'b1;
        tick_b = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        tick_a = 1'b0;
        tick_b = 1'b0;
        ph_a = 3;
        ph_b = 3;
        cnt_b = 0;
        chk("R9 reset over tick a", coil_a, 4'b1000);
        chk("R9 reset over tick b", coil_b, 4'b1000);
        @(negedge clk) tick_a = 1'b1;
        @(negedge clk) tick_a = 1'b0;
        chk("R9 restart at A", coil_a, 4'b0001);
        ph_a = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        t_sequence();
        t_idle();
        t_back_to_back();
        t_first_step();
        t_divided();
        t_reset_collide();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule